// File: doc/BRIEF.md
# GPIO Register Bank with Input Polarity Inversion

This block holds the per-pin register state of a general-purpose I/O expander. A serial-bus front end addresses it through a 2-bit command pointer and single-cycle write and read strobes. The pointer selects one of four byte-wide views:

- the sampled pin levels (read-only);
- the output data latch;
- a per-bit polarity mask that is applied to the sampled pins on read;
- a per-bit direction register.

On the pad side, the block drives an output-enable and an output-data bit for each tri-state pad. It takes the raw pin levels back in through a two-stage synchronizer.

Direction bits decide which pads are driven. A direction bit of 1 makes the pin an input and leaves its pad undriven. A bit of 0 makes the pin an output, and the pad carries the output latch value. A read of the pin view always shows the synchronized pad level, whatever the direction, XORed with the polarity mask. A read of the output latch shows the stored flop value, not the pad. The asynchronous active-low reset forces every register to its default and holds it there while the reset is low.

Top module: `gpio_port_bank`

## Requirements
- R1: While and after reset, the output latch reads 0xFF, the polarity mask reads 0x00, the direction register reads 0xFF, `rd_data_o` is 0x00, and `pad_oe_o` and `pad_do_o` are all zero.
- R2: Command value 1 selects the output latch. A write with `wr_stb_i` high updates it at that clock edge, and a later read returns the written byte.
- R3: Command value 2 selects the polarity mask, which reads back as written. Each mask bit at 1 inverts the same bit of the pin view on read.
- R4: Command value 3 selects the direction register, which reads back as written. After a write, `pad_oe_o` equals the bitwise inverse of the written byte (1 = input, 0 = output).
- R5: A write with command value 0 changes no register. Every later read returns the same values as before that write.
- R6: Command value 0 reads the synchronized pin levels XOR the polarity mask. This holds for every bit, including bits configured as outputs.
- R7: A read of the output latch returns the stored value even when the pin levels differ from it.
- R8: `pad_do_o` is 0 on every bit whose direction bit is 1, and equals the output latch bit on every bit whose direction bit is 0.
- R9: Pin levels reach the pin view through two flops. A read strobed at the first edge after a pin change returns the old level. A read strobed three edges later returns the new level.
- R10: Lowering `rst_ni` between clock edges returns `pad_oe_o` and `pad_do_o` to zero before the next edge.
- R11: `rd_data_o` is loaded only at an edge where `rd_stb_i` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | Register write strobe |
| rd_stb_i | input | 1 | Register read strobe |
| cmd_i | input | 2 | Register pointer: 0 pins, 1 output latch, 2 polarity, 3 direction |
| wr_data_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Read data, valid from the edge after the read strobe |
| pin_i | input | WIDTH | Raw pad levels |
| pad_oe_o | output | WIDTH | Pad driver enable, 1 = drive |
| pad_do_o | output | WIDTH | Pad output data |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, every register value and pin pattern fits in a byte that can be compared whole. The chosen patterns give mixed directions, in which half the pins drive and half float. That makes the effects that cross between registers visible in a single read:

- polarity inversion on pins that are outputs;
- output-latch readback that disagrees with the pads;
- gating of pad data on input pins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_INV  = 2'd2,
    SEL_DIR  = 2'd3
  } gpx_sel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] OUT_RST = '1,
  parameter logic [WIDTH-1:0] INV_RST = '0,
  parameter logic [WIDTH-1:0] DIR_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  gpx_sel_e         sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] out_q_o,
  output logic [WIDTH-1:0] inv_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  logic out_we, inv_we, dir_we;

  // pin view has no storage here: writes with SEL_PINS fall through
  assign out_we = wr_stb_i && (sel_i == SEL_OUT);
  assign inv_we = wr_stb_i && (sel_i == SEL_INV);
  assign dir_we = wr_stb_i && (sel_i == SEL_DIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= OUT_RST;
      inv_q_o <= INV_RST;
      dir_q_o <= DIR_RST;
    end else begin
      if (out_we) out_q_o <= wr_data_i;
      if (inv_we) inv_q_o <= wr_data_i;
      if (dir_we) dir_q_o <= wr_data_i;
    end
  end

  AST_OUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && sel_i == SEL_OUT) |=> out_q_o == $past(wr_data_i)); // R2
  AST_INV_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && sel_i == SEL_INV) |=> inv_q_o == $past(wr_data_i)); // R3
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && sel_i == SEL_DIR) |=> dir_q_o == $past(wr_data_i)); // R4
  AST_PINS_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && sel_i == SEL_PINS) |=>
      ($stable(out_q_o) && $stable(inv_q_o) && $stable(dir_q_o))); // R5
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux
  import gpx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_stb_i,
  input  gpx_sel_e         sel_i,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic [WIDTH-1:0] inv_i,
  input  logic [WIDTH-1:0] dir_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] rd_next;

  always_comb begin
    unique case (sel_i)
      SEL_PINS: rd_next = pins_i ^ inv_i;
      SEL_OUT:  rd_next = out_i;
      SEL_INV:  rd_next = inv_i;
      SEL_DIR:  rd_next = dir_i;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o)); // R11
  AST_RD_OUT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && sel_i == SEL_OUT) |=> rd_data_o == $past(out_i)); // R7
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpx_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             rd_stb_i,
  input  logic [1:0]       cmd_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_do_o
);
  gpx_sel_e         sel;
  logic [WIDTH-1:0] pins_sync, out_q, inv_q, dir_q;

  assign sel = gpx_sel_e'(cmd_i);

  gpx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pins_sync)
  );

  gpx_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb_i), .sel_i(sel),
    .wr_data_i(wr_data_i), .out_q_o(out_q), .inv_q_o(inv_q), .dir_q_o(dir_q)
  );

  gpx_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_stb_i(rd_stb_i), .sel_i(sel),
    .pins_i(pins_sync), .out_i(out_q), .inv_i(inv_q), .dir_i(dir_q),
    .rd_data_o(rd_data_o)
  );

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_pad
      // input pins keep data low so a floating driver never toggles
      assign pad_oe_o[b] = ~dir_q[b];
      assign pad_do_o[b] = ~dir_q[b] & out_q[b];
    end
  endgenerate

  AST_PAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_do_o & ~pad_oe_o) == '0); // R8
  AST_OE_AFTER_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && cmd_i == 2'd3) |=> pad_oe_o == ~$past(wr_data_i)); // R4
endmodule

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_stb = 1'b0, rd_stb = 1'b0;
  logic [1:0]   cmd = '0;
  logic [W-1:0] wdata = '0, pins = '0;
  logic [W-1:0] rd_data, pad_oe, pad_do;

  int applied = 0, miscomp = 0;
  bit finished = 1'b0;
  bit pend = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  gpio_port_bank #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb),
    .cmd_i(cmd), .wr_data_i(wdata), .rd_data_o(rd_data),
    .pin_i(pins), .pad_oe_o(pad_oe), .pad_do_o(pad_do)
  );

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string t);
    applied++;
    if (got !== exp) begin
      miscomp++;
      $display("FAIL %s: got %02h expected %02h", t, got, exp);
    end
  endtask

  // monitor: pops expected read results one cycle after the strobe edge
  always @(posedge clk) pend <= rd_stb && rst_n;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk(rd_data, 'x, "scoreboard underrun");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_write(input logic [1:0] c, input logic [W-1:0] d);
    @(negedge clk);
    cmd = c; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] c, input logic [W-1:0] e, input string t);
    @(negedge clk);
    cmd = c; rd_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscomp++; applied++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    #1;
    chk(rd_data, 8'h00, "R1 rd_data in reset");
    chk(pad_oe, 8'h00, "R1 pad_oe in reset");
    chk(pad_do, 8'h00, "R1 pad_do in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    do_read(2'd1, 8'hFF, "R1 out latch default");
    do_read(2'd2, 8'h00, "R1 polarity default");
    do_read(2'd3, 8'hFF, "R1 direction default");

    do_write(2'd1, 8'h5A);
    do_read(2'd1, 8'h5A, "R2 out latch readback");
    chk(pad_do, 8'h00, "R8 pad_do with all inputs");

    do_write(2'd3, 8'hF0);
    do_read(2'd3, 8'hF0, "R4 direction readback");
    chk(pad_oe, 8'h0F, "R4 pad_oe inverse of direction");
    chk(pad_do, 8'h0A, "R8 pad_do gated by direction");

    @(negedge clk); pins = 8'h3C;
    idle(4);
    do_read(2'd0, 8'h3C, "R6 pins visible on both directions");
    do_read(2'd1, 8'h5A, "R7 out latch not pin level");

    do_write(2'd2, 8'hFF);
    do_read(2'd2, 8'hFF, "R3 polarity readback");
    do_read(2'd0, 8'hC3, "R3 inverted pin view");
    do_write(2'd2, 8'h0F);
    do_read(2'd0, 8'h33, "R3 partial inversion");

    do_write(2'd0, 8'h00);
    do_read(2'd0, 8'h33, "R5 pin view after write to cmd 0");
    do_read(2'd1, 8'h5A, "R5 out latch after write to cmd 0");
    do_read(2'd2, 8'h0F, "R5 polarity after write to cmd 0");
    do_read(2'd3, 8'hF0, "R5 direction after write to cmd 0");

    // R9: change pins in the same cycle as the strobe
    @(negedge clk);
    pins = 8'h81; cmd = 2'd0; rd_stb = 1'b1;
    exp_q.push_back(8'h3C ^ 8'h0F); tag_q.push_back("R9 old level at first edge");
    @(negedge clk); rd_stb = 1'b0;
    idle(2);
    do_read(2'd0, 8'h81 ^ 8'h0F, "R9 new level after sync");

    // R11: pointer moves without strobe, data holds
    @(negedge clk); cmd = 2'd3; pins = 8'hFF;
    idle(3);
    chk(rd_data, 8'h8E, "R11 rd_data holds without strobe");

    do_write(2'd3, 8'h00);
    chk(pad_oe, 8'hFF, "R4 all outputs enabled");
    chk(pad_do, 8'h5A, "R8 pad_do follows out latch");

    // R10: async reset between edges
    @(negedge clk); #3 rst_n = 1'b0; #2;
    chk(pad_oe, 8'h00, "R10 pad_oe async clear");
    chk(pad_do, 8'h00, "R10 pad_do async clear");
    chk(rd_data, 8'h00, "R10 rd_data async clear");
    @(negedge clk); rst_n = 1'b1;
    do_read(2'd1, 8'hFF, "R1 out latch after second reset");
    do_read(2'd3, 8'hFF, "R1 direction after second reset");
    idle(2);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "scoreboard leftover");
    summary();
  end
endmodule